// File: doc/BRIEF.md
# Page-Granular Memory Protection Checker

This block observes the memory requests a CPU issues and checks each one against four protected windows, each exactly one 1024-byte page. Every window holds a page number and a two-bit permission code. A request whose page number (the physical address shifted right by ten) equals a window's page number is checked against that window's code. If the code does not permit the request, the window's own interrupt flag is set and the faulting address is captured. A single interrupt line is driven from the flags, which are gated by per-window enables and one global enable.

Software reaches the configuration through a 16-bit register port addressed by halfword index. Each 32-bit page number is split over two consecutive halfwords, most significant half first. The block only reports violations. It does not stop, delay or complete the offending access.

Top module: `page_guard`

## Requirements
- R1: After reset the flags read 0, the enable register reads 0, the permission register reads 0x00FF (every window allows reads and writes), and `irq` is low.
- R2: A request hits window i only when req_addr >> 10 equals that window's 32-bit page number. The last byte of the preceding page and the first byte of the following page do not hit it.
- R3: Permission codes: 00 refuses reads and writes, 01 allows reads only, 10 allows writes only, 11 allows both. A refused request that hits window i is a violation of window i.
- R4: A violation of window i sets flag bit i at the clock edge that samples the request. Other windows' flags are left unchanged.
- R5: When one request hits several windows, every window that refuses it sets its flag.
- R6: Writing to the flag register (index 10, bits 3:0) clears each bit written as 1 and leaves each bit written as 0 unchanged. A violation in the same cycle as the clearing write leaves that flag set.
- R7: `irq` is high exactly when the global enable (index 9, bit 4) is set and some flag bit i is set whose enable bit i (index 9, bits 3:0) is also set.
- R8: On each violation, req_addr[29:16] is captured into bits 13:0 of index 11, and req_addr[15:5] into bits 15:5 of index 12. All other bits of those registers read 0. The most recent violation overwrites the earlier capture.
- R9: The page number of window i is read and written as its upper half at index 2i and its lower half at index 2i+1.
- R10: The permission register (index 8) holds window i's code in bits 2i+1:2i. Bits 15:8 read 0.
- R11: When req_valid is low, no flag and no captured address changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A memory request is present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Physical byte address of the request |
| reg_en | input | 1 | Register port select |
| reg_we | input | 1 | Register write strobe (qualified by reg_en) |
| reg_idx | input | 4 | Halfword register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_idx (combinational) |
| irq | output | 1 | Masked interrupt request |

## Verification
The four windows are programmed with all four permission codes, and each is sent both a read and a write. This shows whether the code decoding is right and whether each flag lands on its own bit. Two windows are then given the same page with different codes, which tells the all-refusers rule apart from a priority pick. Addresses just outside and just inside a page edge separate an exact page compare from an off-by-one. Clearing writes with zero bits, a clear that coincides with a violation, and enable patterns with and without the global bit separate write-one-to-clear and the interrupt gating from simpler readings.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int NWIN       = 4;
  localparam int PAGE_SHIFT = 10;
  localparam int REG_W      = 16;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RD   = 2'b01,
    PERM_WR   = 2'b10,
    PERM_RW   = 2'b11
  } perm_e;

  localparam logic [3:0] IDX_PERM   = 4'd8;
  localparam logic [3:0] IDX_ENABLE = 4'd9;
  localparam logic [3:0] IDX_FLAGS  = 4'd10;
  localparam logic [3:0] IDX_FLT_HI = 4'd11;
  localparam logic [3:0] IDX_FLT_LO = 4'd12;
endpackage

// File: rtl/pg_window.sv
module pg_window
  import pg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       page,
  input  logic [1:0]        perm,
  output logic              viol
);
  logic hit;
  logic allowed;

  always_comb begin
    hit     = (page == 32'(req_addr >> PAGE_SHIFT));
    allowed = req_write ? perm[1] : perm[0];
    viol    = req_valid && hit && !allowed;
  end

  // R3: a refusing code on a hit always produces a violation
  a_r3_deny_all: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && perm == PERM_NONE && page == 32'(req_addr >> PAGE_SHIFT)) |-> viol);
  // R11: no request, no violation
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !viol);
endmodule

// File: rtl/pg_regs.sv
module pg_regs
  import pg_pkg::*;
#(
  parameter int N = NWIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       idx,
  input  logic [REG_W-1:0] wdata,
  output logic [31:0]      page_q [N],
  output logic [2*N-1:0]   perm_q,
  output logic [N:0]       enable_q
);
  logic [31:0]    page_d [N];
  logic [2*N-1:0] perm_d;
  logic [N:0]     enable_d;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      page_d[i] = page_q[i];
      if (wr_en && idx == 4'(2*i))   page_d[i][31:16] = wdata;
      if (wr_en && idx == 4'(2*i+1)) page_d[i][15:0]  = wdata;
    end
    perm_d   = (wr_en && idx == IDX_PERM)   ? wdata[2*N-1:0] : perm_q;
    enable_d = (wr_en && idx == IDX_ENABLE) ? wdata[N:0]     : enable_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) page_q[i] <= '0;
      perm_q   <= '1;
      enable_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) page_q[i] <= page_d[i];
      perm_q   <= perm_d;
      enable_q <= enable_d;
    end
  end

  // R10: permissions move only on a write to their register
  a_r10_perm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && idx == IDX_PERM) |=> $stable(perm_q));
endmodule

// File: rtl/pg_irq.sv
module pg_irq
  import pg_pkg::*;
#(
  parameter int N      = NWIN,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      viol,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              clr_en,
  input  logic [N-1:0]      clr_bits,
  input  logic [N:0]        enable,
  output logic [N-1:0]      flags_q,
  output logic [13:0]       flt_hi_q,
  output logic [10:0]       flt_lo_q,
  output logic              irq
);
  logic [N-1:0] flags_d;
  logic [13:0]  flt_hi_d;
  logic [10:0]  flt_lo_d;
  logic         any_viol;

  always_comb begin
    any_viol = |viol;
    flags_d  = (flags_q & ~(clr_en ? clr_bits : '0)) | viol;
    flt_hi_d = any_viol ? req_addr[29:16] : flt_hi_q;
    flt_lo_d = any_viol ? req_addr[15:5]  : flt_lo_q;
    irq      = enable[N] && |(flags_q & enable[N-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q  <= '0;
      flt_hi_q <= '0;
      flt_lo_q <= '0;
    end else begin
      flags_q  <= flags_d;
      flt_hi_q <= flt_hi_d;
      flt_lo_q <= flt_lo_d;
    end
  end

  // R4: a flag rises only after a violation was seen
  a_r4_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_q & ~$past(flags_q))) |-> $past(any_viol));
  // R6: a flag falls only after a clearing write
  a_r6_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags_q) & ~flags_q)) |-> $past(clr_en));
  // R7: the line needs a pending flag
  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags_q != '0));
  // R8: capture follows the violating address
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    any_viol |=> (flt_hi_q == $past(req_addr[29:16])));
endmodule

// File: rtl/page_guard.sv
module page_guard
  import pg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [3:0]        reg_idx,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              irq
);
  localparam int N = NWIN;

  logic [31:0]    page_q [N];
  logic [2*N-1:0] perm_q;
  logic [N:0]     enable_q;
  logic [N-1:0]   viol;
  logic [N-1:0]   flags_q;
  logic [13:0]    flt_hi_q;
  logic [10:0]    flt_lo_q;
  logic           wr_en;

  assign wr_en = reg_en && reg_we;

  pg_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(reg_idx), .wdata(reg_wdata),
    .page_q(page_q), .perm_q(perm_q), .enable_q(enable_q)
  );

  for (genvar g = 0; g < N; g++) begin : g_win
    pg_window #(.ADDR_W(ADDR_W)) u_win (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .page(page_q[g]), .perm(perm_q[2*g+1:2*g]),
      .viol(viol[g])
    );
  end

  pg_irq #(.N(N), .ADDR_W(ADDR_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .viol(viol), .req_addr(req_addr),
    .clr_en(wr_en && reg_idx == IDX_FLAGS), .clr_bits(reg_wdata[N-1:0]),
    .enable(enable_q), .flags_q(flags_q), .flt_hi_q(flt_hi_q),
    .flt_lo_q(flt_lo_q), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < N; i++) begin
      if (reg_idx == 4'(2*i))   reg_rdata = page_q[i][31:16];
      if (reg_idx == 4'(2*i+1)) reg_rdata = page_q[i][15:0];
    end
    case (reg_idx)
      IDX_PERM:   reg_rdata = 16'(perm_q);
      IDX_ENABLE: reg_rdata = 16'(enable_q);
      IDX_FLAGS:  reg_rdata = 16'(flags_q);
      IDX_FLT_HI: reg_rdata = 16'(flt_hi_q);
      IDX_FLT_LO: reg_rdata = {flt_lo_q, 5'b0};
      default: ;
    endcase
  end

  // R1: reset leaves the line low
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);
endmodule

// File: tb/page_guard_bench.sv
module page_guard_bench;
  logic        clk = 0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic        reg_en, reg_we;
  logic [3:0]  reg_idx;
  logic [15:0] reg_wdata, reg_rdata;
  logic        irq;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  page_guard u_page_guard (.*);

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] idx, logic [15:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(logic [3:0] idx, output logic [15:0] d);
    reg_idx = idx; #1; d = reg_rdata;
  endtask

  task automatic access(logic [31:0] a, logic w);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_flags(string tag, logic [15:0] exp);
    logic [15:0] v;
    rd(4'd10, v); check(tag, v, exp);
    wr(4'd10, 16'h000F);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(4'd10, v); check("R1 flags", v, 16'h0);
    rd(4'd9, v);  check("R1 enable", v, 16'h0);
    rd(4'd8, v);  check("R1 perm", v, 16'h00FF);
    check("R1 irq", 16'(irq), 16'h0);
  endtask

  task automatic t_regmap;
    logic [15:0] v;
    wr(4'd4, 16'h0003); wr(4'd5, 16'h1234);
    rd(4'd4, v); check("R9 upper half", v, 16'h0003);
    rd(4'd5, v); check("R9 lower half", v, 16'h1234);
    wr(4'd8, 16'hFFE4);
    rd(4'd8, v); check("R10 perm layout", v, 16'h00E4);
  endtask

  task automatic t_perm;
    // windows: 0 page 0x100 code 00, 1 page 0x200 code 01, 2,3 page 0x300 codes 10,11
    wr(4'd1, 16'h0100); wr(4'd3, 16'h0200);
    wr(4'd4, 16'h0000); wr(4'd5, 16'h0300);
    wr(4'd7, 16'h0300);
    access(32'h0004_0000, 0); expect_flags("R3 code00 read", 16'h1);
    access(32'h0004_0010, 1); expect_flags("R3 code00 write", 16'h1);
    access(32'h0008_0000, 0); expect_flags("R3 code01 read", 16'h0);
    access(32'h0008_0000, 1); expect_flags("R4 code01 write", 16'h2);
    access(32'h000C_0000, 0); expect_flags("R3 code10 read", 16'h4);
    access(32'h000C_0000, 1); expect_flags("R3 code10/11 write", 16'h0);
    wr(4'd8, 16'h0024);
    access(32'h000C_0100, 0); expect_flags("R5 two refusers", 16'hC);
  endtask

  task automatic t_edge;
    access(32'h0003_FFFF, 0); expect_flags("R2 below page", 16'h0);
    access(32'h0004_0400, 0); expect_flags("R2 above page", 16'h0);
    access(32'h0004_03FF, 0); expect_flags("R2 last byte", 16'h1);
  endtask

  task automatic t_idle;
    logic [15:0] v;
    @(negedge clk); req_valid = 0; req_addr = 32'h0004_0000; req_write = 0;
    @(negedge clk);
    rd(4'd10, v); check("R11 idle flags", v, 16'h0);
    rd(4'd11, v); check("R11 idle capture", v, 16'h0004);
  endtask

  task automatic t_clear;
    logic [15:0] v;
    access(32'h0004_0000, 0); access(32'h0008_0000, 1);
    wr(4'd10, 16'h0000);
    rd(4'd10, v); check("R6 zero write keeps", v, 16'h3);
    wr(4'd10, 16'h0001);
    rd(4'd10, v); check("R6 one clears", v, 16'h2);
    @(negedge clk);
    req_valid = 1; req_addr = 32'h0004_0000; req_write = 0;
    reg_en = 1; reg_we = 1; reg_idx = 4'd10; reg_wdata = 16'h0001;
    @(negedge clk);
    req_valid = 0; reg_en = 0; reg_we = 0;
    rd(4'd10, v); check("R6 set beats clear", v, 16'h3);
    wr(4'd10, 16'h0001);
  endtask

  task automatic t_irq;
    wr(4'd9, 16'h0002); check("R7 global off", 16'(irq), 16'h0);
    wr(4'd9, 16'h0012); check("R7 enabled flag", 16'(irq), 16'h1);
    wr(4'd9, 16'h0011); check("R7 masked flag", 16'(irq), 16'h0);
    wr(4'd10, 16'h000F); wr(4'd9, 16'h001F);
    check("R7 no flag", 16'(irq), 16'h0);
  endtask

  task automatic t_capture;
    logic [15:0] v;
    wr(4'd2, 16'h000D); wr(4'd3, 16'h69E5);
    access(32'h35A7_96E4, 1);
    rd(4'd11, v); check("R8 upper bits", v, 16'h35A7);
    rd(4'd12, v); check("R8 lower bits", v, 16'h96E0);
    access(32'h0004_0000, 0);
    rd(4'd11, v); check("R8 latest upper", v, 16'h0004);
    rd(4'd12, v); check("R8 latest lower", v, 16'h0000);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0;
    reg_en = 0; reg_we = 0; reg_idx = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_regmap;
    t_perm;
    t_edge;
    t_idle;
    t_clear;
    t_irq;
    t_capture;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule